// File: doc/BRIEF.md
# Interface Clock Frequency Meter

This block measures how fast an asynchronous interface clock runs compared with a free-running reference clock. It counts measured-clock edges in the measured domain and moves that count into the reference domain as a Gray code through a two-flop synchronizer. Once per window of reference cycles it turns the count into a 32-bit unsigned 16.16 fixed-point ratio. One LSB of the result is the reference frequency divided by 65536. The result reads 1.0 (0x0001_0000) when the two clocks run at the same rate.

The window length is 2^WIN_LOG2 reference cycles, with WIN_LOG2 = 16 by default. A shorter window, for quicker updates, is allowed for WIN_LOG2 up to 16. The raw count is then shifted left by 16 - WIN_LOG2, so the result keeps the 16.16 format at a coarser resolution. The result holds its value between window ends. Software reads it directly. Any further clock ratio, and any conversion to a sampling rate, is applied outside this block.

Top module: `clk_freq_meter`

## Requirements
- R1: While reset is applied and after it is released, freq_o reads 0 until the first window completes.
- R2: A window lasts exactly 2^WIN_LOG2 reference cycles counted from reset release. freq_o first takes a new value on reference edge number 2^WIN_LOG2, and then on every later multiple of 2^WIN_LOG2.
- R3: freq_o equals the number of measured-clock edges seen in the last window, shifted left by 16 - WIN_LOG2. This is an unsigned 16.16 ratio in which 0x0001_0000 means equal frequencies. A measured clock at half the reference rate reads 0x0000_8000, within one count.
- R4: A measured clock faster than the reference is reported with an integer part greater than zero. At 2.5 times the reference rate it reads 0x0002_8000, within one count.
- R5: If the measured clock stops, the first window that lies wholly after the stop reports 0.
- R6: Between window ends freq_o holds its value unchanged.
- R7: The measured-domain counter crosses domains as a Gray code that changes at most one bit per measured edge, so the count stays correct when the measured clock runs faster than the reference.
- R8: A slow measured clock at one eighth of the reference rate reads 0x0000_2000, within one count.
- R9: After a stopped measured clock restarts, the second completed window after the restart again reports the correct ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset, reference domain |
| meas_clk_i | input | 1 | Clock being measured |
| meas_rst_ni | input | 1 | Active-low asynchronous reset, measured domain |
| freq_o | output | 32 | Measured/reference frequency ratio, unsigned 16.16 |

## Verification
The measured clock is run at one half, two and a half, and one eighth of the reference rate. These three rates separate a result below unity from one with an integer part, and show that the shift scaling is correct at both ends. The half rate also pins down the first update edge and the hold behaviour between updates. The two and a half rate shows that a counter advancing faster than the sampling clock still crosses domains correctly. Stopping the measured clock checks that the reading falls to zero. Restarting it checks that stale state from before the stop does not carry over.

// File: rtl/clk_meter_pkg.sv
package clk_meter_pkg;

  localparam int unsigned WordW = 32;
  typedef logic [WordW-1:0] word_t;

  function automatic word_t bin2gray(input word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic word_t gray2bin(input word_t g);
    word_t b;
    b[WordW-1] = g[WordW-1];
    for (int i = WordW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/cm_gray_counter.sv
module cm_gray_counter
  import clk_meter_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;
  logic [CNT_W-1:0] gray_q;

  assign bin_nxt = bin_q + 1'b1;

  // gray taken straight from a flop so the crossing sees glitch-free bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= CNT_W'(bin2gray(word_t'(bin_nxt)));
    end
  end

  assign gray_o = gray_q;

  // R7: at most one bit changes per measured edge
  a_r7_gray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/cm_window.sv
module cm_window #(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic [WIN_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // last cycle of the window
  assign tick_o = &cnt_q;

  // R2: window restarts from zero right after its last cycle
  a_r2_window_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

  // R2: a single end-of-window cycle per window
  a_r2_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import clk_meter_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic        ref_clk_i,
  input  logic        rst_ni,
  input  logic        meas_clk_i,
  input  logic        meas_rst_ni,
  output logic [31:0] freq_o
);

  localparam int unsigned FracW = 16;
  localparam int unsigned CntW  = WIN_LOG2 + FracW;
  localparam int unsigned Shift = FracW - WIN_LOG2;

  logic [CntW-1:0] meas_gray;
  logic [CntW-1:0] sync_gray;
  logic [CntW-1:0] cur_bin;
  logic [CntW-1:0] prev_q;
  logic [CntW-1:0] delta;
  logic [31:0]     freq_q;
  logic [31:0]     freq_d;
  logic            tick;

  cm_gray_counter #(.CNT_W(CntW)) i_cnt (
    .clk_i  (meas_clk_i),
    .rst_ni (meas_rst_ni),
    .gray_o (meas_gray)
  );

  cm_sync #(.W(CntW)) i_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (meas_gray),
    .q_o    (sync_gray)
  );

  cm_window #(.WIN_LOG2(WIN_LOG2)) i_win (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign cur_bin = CntW'(gray2bin(word_t'(sync_gray)));
  assign delta   = cur_bin - prev_q;
  // scale count to 16.16 regardless of window length
  assign freq_d  = 32'(delta) << Shift;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      freq_q <= '0;
    end else if (tick) begin
      prev_q <= cur_bin;
      freq_q <= freq_d;
    end
  end

  assign freq_o = freq_q;

  // R6: result moves only right after a window end
  a_r6_hold: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !tick |=> $stable(freq_o));

  // R5: no measured progress over a window reports zero
  a_r5_idle_zero: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (tick && cur_bin == prev_q) |=> (freq_o == '0));

  // R1: result is zero while reset is held
  a_r1_reset_zero: assert property (@(posedge ref_clk_i)
    !rst_ni |-> (freq_o == '0));

endmodule

// File: tb/test_clk_freq_meter.sv
`timescale 1ns/1ps
module test_clk_freq_meter;

  localparam int unsigned WinLog2 = 10;
  localparam int unsigned Win     = 1 << WinLog2;
  localparam int unsigned Tol     = 1 << (16 - WinLog2);

  logic        ref_clk = 1'b0;
  logic        meas_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        meas_rst_ni = 1'b0;
  logic [31:0] freq;
  logic        meas_run = 1'b1;
  int          meas_half = 20;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  clk_freq_meter #(.WIN_LOG2(WinLog2)) i_clk_freq_meter (
    .ref_clk_i   (ref_clk),
    .rst_ni      (rst_ni),
    .meas_clk_i  (meas_clk),
    .meas_rst_ni (meas_rst_ni),
    .freq_o      (freq)
  );

  always #10 ref_clk = ~ref_clk;

  initial begin
    #3;
    forever begin
      #(meas_half);
      if (meas_run) meas_clk = ~meas_clk;
    end
  end

  always @(posedge ref_clk) if (rst_ni) cyc <= cyc + 1;

  task automatic wait_cyc(input int target);
    do @(negedge ref_clk); while (cyc < target);
  endtask

  task automatic check_near(input string tag, input logic [31:0] act,
                            input logic [31:0] exp, input int tol);
    int diff;
    checks++;
    diff = (act > exp) ? int'(act - exp) : int'(exp - act);
    if (diff > tol) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    check_near("R1 during reset", freq, 32'h0, 0);
    @(negedge ref_clk);
    rst_ni = 1'b1;
    meas_rst_ni = 1'b1;
    wait_cyc(5);
    check_near("R1 after release", freq, 32'h0, 0);
  endtask

  task automatic t_first_window;
    wait_cyc(Win - 1);
    check_near("R2 before first edge", freq, 32'h0, 0);
    wait_cyc(Win);
    checks++;
    if (freq == 32'h0) begin
      errors++;
      $display("FAIL R2 first update: actual 0x%08h expected nonzero", freq);
    end
  endtask

  task automatic t_half_rate;
    logic [31:0] held;
    wait_cyc(2 * Win + 1);
    held = freq;
    check_near("R3 half rate", freq, 32'h0000_8000, Tol);
    wait_cyc(3 * Win - 1);
    check_near("R6 hold in window", freq, held, 0);
  endtask

  task automatic t_fast_rate;
    wait_cyc(3 * Win + Win / 2);
    meas_half = 4;
    wait_cyc(5 * Win + Win / 2);
    check_near("R4 R7 rate 2.5", freq, 32'h0002_8000, Tol);
  endtask

  task automatic t_slow_rate;
    meas_half = 80;
    wait_cyc(7 * Win + Win / 2);
    check_near("R8 rate 1/8", freq, 32'h0000_2000, Tol);
  endtask

  task automatic t_stop;
    meas_run = 1'b0;
    wait_cyc(9 * Win + Win / 2);
    check_near("R5 stopped", freq, 32'h0, 0);
    wait_cyc(10 * Win + 100);
    check_near("R6 hold stopped", freq, 32'h0, 0);
  endtask

  task automatic t_restart;
    wait_cyc(10 * Win + Win / 2);
    meas_half = 20;
    meas_run = 1'b1;
    wait_cyc(12 * Win + Win / 2);
    check_near("R9 restart", freq, 32'h0000_8000, Tol);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #25;
    t_reset();
    t_first_window();
    t_half_rate();
    t_fast_rate();
    t_slow_rate();
    t_stop();
    t_restart();
    finish_run();
  end

endmodule